// File: doc/BRIEF.md
# SD Card SPI-Mode Initialization Sequencer

This host-side block takes a memory card operating in SPI mode from power-up to a usable state. It sits between user logic and a byte-wide transfer engine: each byte it hands over is shifted out while one byte is shifted in, and the engine answers with a one-cycle completion pulse carrying the received byte. The sequencer generates the wake-up clocks, builds every 6-byte command frame (including its CRC7), collects R1 responses and the four extra OCR bytes of CMD58, and walks the card through reset, operating-condition polling and a supply-voltage check.

After a `start` pulse the state machine moves `S_OFF -> S_DUMMY` (chip select high, filler bytes), then `S_CMD -> S_RESP -> S_EVAL` for CMD0. From `S_EVAL` it loops `S_CMD -> S_RESP -> S_EVAL` with CMD1 while the card reports idle, then issues CMD58 (`S_CMD -> S_RESP -> S_OCR -> S_EVAL`) and settles in `S_READY`, or in `S_FAIL` on a missing response, an unexpected R1, an exhausted poll budget or a voltage mismatch. From `S_READY` or `S_FAIL` the user may issue single commands (`S_READY/S_FAIL -> S_CMD -> ... -> S_EVAL -> back`); commands that an idle card cannot accept are refused without touching the bus. The transfer-clock enable is low whenever no byte is pending, so the serial clock can be stopped between transactions.

Top module: `sdinit_seq`

## Requirements
- R1: After `start`, exactly DUMMY_BYTES (default 10, i.e. 80 clocks) bytes of 0xFF are transferred with `cs_n` high before the first command frame; every byte sent with `cs_n` high is 0xFF.
- R2: The first frame after `start` is CMD0 with a zero argument, sent as bytes 0x40 0x00 0x00 0x00 0x00 0x95.
- R3: Each frame is 6 bytes sent with `cs_n` low: byte 0 = `01` followed by the 6-bit index, bytes 1..4 = argument most significant byte first, byte 5 = CRC7 (polynomial x^7+x^3+1 over the first 40 bits) in bits 7..1 with bit 0 = 1; the transmit byte is held stable until its completion pulse.
- R4: After a frame the block sends 0xFF bytes until a received byte has bit 7 = 0 (taken as R1), at most NCR_BYTES (default 8) bytes; this fixed window applies to every command, including a CSD read (CMD9). With no response during start-up it ends in `S_FAIL` with `fail_code` = 1; for a user command it reports `cmd_noresp` = 1 and `cmd_r1` = 0xFF.
- R5: A CMD0 response other than 0x01 ends start-up with `fail_code` = 2.
- R6: CMD1 is sent with an all-zero argument (also when a user requests it with another argument) and repeated while R1 = 0x01; R1 = 0x00 ends polling.
- R7: When `poll_max` CMD1 responses in a row report idle (0x01), start-up ends with `fail_code` = 3 and no further CMD1 is sent; any other R1 value during polling gives `fail_code` = 2.
- R8: After polling, CMD58 is sent; its R1 is followed by 4 OCR bytes, most significant first, which appear on `ocr`.
- R9: If OCR bits 23..0 do not include every bit of HOST_VMASK (default 0x300000), start-up ends with `fail_code` = 4; otherwise `ready` rises with `fail_code` = 0. `ready` and `fail` are never both high.
- R10: `sclk_en` is high only while a byte transfer is requested; it is low in `S_OFF`, `S_EVAL`, `S_READY` and `S_FAIL`.
- R11: While the card is idle (since reset, or the last R1 had bit 0 = 1), a user request with an index other than 1, 41, 58 or 59 is refused: `cmd_blocked` pulses one cycle later and no transfer starts.
- R12: A permitted user request in `S_READY` or `S_FAIL` sends its frame, pulses `cmd_done` with `cmd_r1`, updates `ocr` for CMD58, and returns to the state it came from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the start-up sequence (accepted in `S_OFF`) |
| poll_max | input | POLL_W | Number of idle CMD1 responses tolerated |
| user_cmd_valid | input | 1 | One-cycle user command request |
| user_cmd_idx | input | 6 | User command index |
| user_cmd_arg | input | 32 | User command argument |
| xfer_req | output | 1 | Byte transfer requested |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | Transfer complete pulse |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |
| cs_n | output | 1 | Card chip select, active low |
| sclk_en | output | 1 | Serial clock enable |
| busy | output | 1 | Sequencer active |
| ready | output | 1 | Start-up completed |
| fail | output | 1 | Start-up failed |
| fail_code | output | 3 | 0 none, 1 no response, 2 bad R1, 3 poll timeout, 4 voltage |
| ocr | output | 32 | Last OCR read |
| cmd_done | output | 1 | User command finished (pulse) |
| cmd_r1 | output | 8 | R1 of the last user command |
| cmd_noresp | output | 1 | Last user command got no response |
| cmd_blocked | output | 1 | User request refused (pulse) |

## Verification
The bench drives a card model that answers late in the response window: an R1 in the eighth byte must be accepted while one in the ninth must count as silence, so an off-by-one window either fails good cards or hangs on dead ones. The poll limit is probed at exactly its value and one below, where a wrong compare sends one CMD1 too many or gives up one too early. An OCR lacking the host voltage bits must stop in the fail state rather than report ready, and a non-permitted command to an idle card must produce a refusal pulse with a silent bus, where a faulty filter would emit a frame the card model flags. Every frame is compared byte for byte, CRC included, against a queue of expected frames, which catches a wrong CMD0 CRC, a non-zero CMD1 argument or stray extra polls.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [2:0] {
        S_OFF, S_DUMMY, S_CMD, S_RESP, S_OCR, S_EVAL, S_READY, S_FAIL
    } state_t;

    typedef enum logic [1:0] {
        P_RST, P_POLL, P_OCR, P_USER
    } phase_t;

    localparam logic [2:0] FC_NONE    = 3'd0;
    localparam logic [2:0] FC_NORESP  = 3'd1;
    localparam logic [2:0] FC_BADR1   = 3'd2;
    localparam logic [2:0] FC_TIMEOUT = 3'd3;
    localparam logic [2:0] FC_VOLT    = 3'd4;

    localparam logic [5:0] IDX_RESET  = 6'd0;
    localparam logic [5:0] IDX_OPCOND = 6'd1;
    localparam logic [5:0] IDX_APPOP  = 6'd41;
    localparam logic [5:0] IDX_RDOCR  = 6'd58;
    localparam logic [5:0] IDX_CRCSW  = 6'd59;

    function automatic logic idle_permits(input logic [5:0] i);
        return (i == IDX_OPCOND) || (i == IDX_APPOP) ||
               (i == IDX_RDOCR)  || (i == IDX_CRCSW);
    endfunction

endpackage

// File: rtl/sdinit_counter.sv
module sdinit_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (cnt != {W{1'b1}}));

endmodule

// File: rtl/sdinit_frame.sv
module sdinit_frame #(
    parameter int POS_W = 4
) (
    input  logic [5:0]       idx,
    input  logic [31:0]      arg,
    input  logic [POS_W-1:0] pos,
    output logic [7:0]       byte_o
);

    function automatic logic [6:0] crc7(input logic [39:0] m);
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            fb = m[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    logic [39:0] head;
    logic [6:0]  crc;

    always_comb begin
        head = {2'b01, idx, arg};
        crc  = crc7(head);
        if      (pos == POS_W'(0)) byte_o = head[39:32];
        else if (pos == POS_W'(1)) byte_o = arg[31:24];
        else if (pos == POS_W'(2)) byte_o = arg[23:16];
        else if (pos == POS_W'(3)) byte_o = arg[15:8];
        else if (pos == POS_W'(4)) byte_o = arg[7:0];
        else if (pos == POS_W'(5)) byte_o = {crc, 1'b1};
        else                       byte_o = 8'hFF;
    end

    // R2
    always_comb begin
        if (idx == 6'd0 && arg == 32'd0 && pos == POS_W'(5))
            reset_crc_chk: assert (byte_o == 8'h95);
    end

endmodule

// File: rtl/sdinit_seq.sv
module sdinit_seq
    import sdinit_pkg::*;
#(
    parameter int          DUMMY_BYTES = 10,
    parameter int          NCR_BYTES   = 8,
    parameter int          POLL_W      = 16,
    parameter logic [23:0] HOST_VMASK  = 24'h30_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [POLL_W-1:0] poll_max,
    input  logic              user_cmd_valid,
    input  logic [5:0]        user_cmd_idx,
    input  logic [31:0]       user_cmd_arg,
    output logic              xfer_req,
    output logic [7:0]        xfer_tx,
    input  logic              xfer_done,
    input  logic [7:0]        xfer_rx,
    output logic              cs_n,
    output logic              sclk_en,
    output logic              busy,
    output logic              ready,
    output logic              fail,
    output logic [2:0]        fail_code,
    output logic [31:0]       ocr,
    output logic              cmd_done,
    output logic [7:0]        cmd_r1,
    output logic              cmd_noresp,
    output logic              cmd_blocked
);

    localparam int FRAME_BYTES = 6;
    localparam int OCR_BYTES   = 4;
    localparam int CNT_A       = (DUMMY_BYTES > NCR_BYTES) ? DUMMY_BYTES : NCR_BYTES;
    localparam int CNT_TOP     = (CNT_A > FRAME_BYTES) ? CNT_A : FRAME_BYTES;
    localparam int CNT_W       = $clog2(CNT_TOP + 1);
    localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_FRAME = CNT_W'(FRAME_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_NCR   = CNT_W'(NCR_BYTES - 1);
    localparam logic [CNT_W-1:0] LAST_OCR   = CNT_W'(OCR_BYTES - 1);

    state_t            state_q, state_d;
    phase_t            phase_q;
    logic [5:0]        idx_q;
    logic [31:0]       arg_q;
    logic [7:0]        r1_q;
    logic              noresp_q;
    logic [31:0]       ocr_sh_q;
    logic              card_idle_q;
    logic              ret_ready_q;
    logic [2:0]        fail_code_q;
    logic [31:0]       ocr_q;

    logic              bc_clr, bc_inc, pc_clr, pc_inc;
    logic [CNT_W-1:0]  bc;
    logic [POLL_W-1:0] pc;
    logic [7:0]        frame_byte;
    logic              poll_over, volt_ok, refuse, boot_ok;

    sdinit_counter #(.W(CNT_W)) byte_ctr_i (
        .clk(clk), .rst_n(rst_n), .clr(bc_clr), .inc(bc_inc), .cnt(bc));

    sdinit_counter #(.W(POLL_W)) poll_ctr_i (
        .clk(clk), .rst_n(rst_n), .clr(pc_clr), .inc(pc_inc), .cnt(pc));

    sdinit_frame #(.POS_W(CNT_W)) frame_i (
        .idx(idx_q), .arg(arg_q), .pos(bc), .byte_o(frame_byte));

    assign poll_over = ({1'b0, pc} + 1'b1) >= {1'b0, poll_max};
    assign volt_ok   = (ocr_sh_q[23:0] & HOST_VMASK) == HOST_VMASK;
    assign refuse    = card_idle_q && !idle_permits(user_cmd_idx);
    assign boot_ok   = !noresp_q && (r1_q == 8'h01);

    // next state and counter control
    always_comb begin
        state_d = state_q;
        bc_clr  = 1'b0;
        bc_inc  = 1'b0;
        pc_clr  = 1'b0;
        pc_inc  = 1'b0;
        unique case (state_q)
            S_OFF: if (start) begin state_d = S_DUMMY; bc_clr = 1'b1; end
            S_DUMMY: if (xfer_done) begin
                if (bc == LAST_DUMMY) begin state_d = S_CMD; bc_clr = 1'b1; end
                else bc_inc = 1'b1;
            end
            S_CMD: if (xfer_done) begin
                if (bc == LAST_FRAME) begin state_d = S_RESP; bc_clr = 1'b1; end
                else bc_inc = 1'b1;
            end
            S_RESP: if (xfer_done) begin
                if (!xfer_rx[7]) begin
                    state_d = (idx_q == IDX_RDOCR) ? S_OCR : S_EVAL;
                    bc_clr  = 1'b1;
                end else if (bc == LAST_NCR) begin
                    state_d = S_EVAL;
                    bc_clr  = 1'b1;
                end else bc_inc = 1'b1;
            end
            S_OCR: if (xfer_done) begin
                if (bc == LAST_OCR) begin state_d = S_EVAL; bc_clr = 1'b1; end
                else bc_inc = 1'b1;
            end
            S_EVAL: unique case (phase_q)
                P_RST: begin
                    state_d = boot_ok ? S_CMD : S_FAIL;
                    pc_clr  = 1'b1;
                end
                P_POLL: begin
                    if (noresp_q)                        state_d = S_FAIL;
                    else if (r1_q == 8'h00)              state_d = S_CMD;
                    else if (r1_q == 8'h01 && !poll_over) begin
                        state_d = S_CMD;
                        pc_inc  = 1'b1;
                    end else                             state_d = S_FAIL;
                end
                P_OCR: state_d = (!noresp_q && r1_q == 8'h00 && volt_ok) ? S_READY : S_FAIL;
                P_USER: state_d = ret_ready_q ? S_READY : S_FAIL;
            endcase
            S_READY, S_FAIL: if (user_cmd_valid && !refuse) begin
                state_d = S_CMD;
                bc_clr  = 1'b1;
            end
            default: state_d = S_OFF;
        endcase
    end

    // state register and sequencing data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= S_OFF;
            phase_q     <= P_RST;
            idx_q       <= IDX_RESET;
            arg_q       <= '0;
            r1_q        <= 8'hFF;
            noresp_q    <= 1'b0;
            ocr_sh_q    <= '0;
            card_idle_q <= 1'b1;
            ret_ready_q <= 1'b0;
            fail_code_q <= FC_NONE;
            ocr_q       <= '0;
            cmd_done    <= 1'b0;
            cmd_r1      <= 8'hFF;
            cmd_noresp  <= 1'b0;
            cmd_blocked <= 1'b0;
        end else begin
            state_q     <= state_d;
            cmd_done    <= 1'b0;
            cmd_blocked <= 1'b0;
            unique case (state_q)
                S_OFF: if (start) begin
                    phase_q     <= P_RST;
                    idx_q       <= IDX_RESET;
                    arg_q       <= '0;
                    fail_code_q <= FC_NONE;
                end
                S_RESP: if (xfer_done) begin
                    if (!xfer_rx[7]) begin
                        r1_q        <= xfer_rx;
                        noresp_q    <= 1'b0;
                        card_idle_q <= xfer_rx[0];
                    end else if (bc == LAST_NCR) begin
                        r1_q     <= 8'hFF;
                        noresp_q <= 1'b1;
                    end
                end
                S_OCR: if (xfer_done) ocr_sh_q <= {ocr_sh_q[23:0], xfer_rx};
                S_EVAL: unique case (phase_q)
                    P_RST: begin
                        if (boot_ok) begin
                            phase_q <= P_POLL;
                            idx_q   <= IDX_OPCOND;
                            arg_q   <= '0;
                        end else fail_code_q <= noresp_q ? FC_NORESP : FC_BADR1;
                    end
                    P_POLL: begin
                        if (noresp_q)            fail_code_q <= FC_NORESP;
                        else if (r1_q == 8'h00) begin
                            phase_q <= P_OCR;
                            idx_q   <= IDX_RDOCR;
                        end else if (r1_q != 8'h01) fail_code_q <= FC_BADR1;
                        else if (poll_over)         fail_code_q <= FC_TIMEOUT;
                    end
                    P_OCR: begin
                        if (noresp_q)            fail_code_q <= FC_NORESP;
                        else if (r1_q != 8'h00)  fail_code_q <= FC_BADR1;
                        else begin
                            ocr_q <= ocr_sh_q;
                            if (!volt_ok) fail_code_q <= FC_VOLT;
                        end
                    end
                    P_USER: begin
                        cmd_done   <= 1'b1;
                        cmd_r1     <= r1_q;
                        cmd_noresp <= noresp_q;
                        if (idx_q == IDX_RDOCR && !noresp_q) ocr_q <= ocr_sh_q;
                    end
                endcase
                S_READY, S_FAIL: if (user_cmd_valid) begin
                    if (refuse) cmd_blocked <= 1'b1;
                    else begin
                        phase_q     <= P_USER;
                        idx_q       <= user_cmd_idx;
                        arg_q       <= (user_cmd_idx == IDX_OPCOND) ? 32'd0 : user_cmd_arg;
                        ret_ready_q <= (state_q == S_READY);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        xfer_req  = (state_q == S_DUMMY) || (state_q == S_CMD) ||
                    (state_q == S_RESP)  || (state_q == S_OCR);
        cs_n      = !((state_q == S_CMD) || (state_q == S_RESP) || (state_q == S_OCR));
        xfer_tx   = (state_q == S_CMD) ? frame_byte : 8'hFF;
        sclk_en   = xfer_req;
        busy      = !((state_q == S_OFF) || (state_q == S_READY) || (state_q == S_FAIL));
        ready     = (state_q == S_READY);
        fail      = (state_q == S_FAIL);
        fail_code = fail_code_q;
        ocr       = ocr_q;
    end

    // R10
    clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk_en);

    // R1
    dummy_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && cs_n) |-> (xfer_tx == 8'hFF));

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_tx)));

    // R11
    refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_blocked |-> !xfer_req);

    // R9
    volt_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(state_q) == S_EVAL && $past(phase_q) == P_OCR)
            |-> ((ocr[23:0] & HOST_VMASK) == HOST_VMASK));

    // R9
    excl_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && fail));

    // R7
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == P_POLL && state_q == S_CMD) |-> (pc == '0 || pc < poll_max));

endmodule

// File: tb/sdinit_seq_tb_top.sv
module sdinit_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] poll_max;
    logic        user_cmd_valid;
    logic [5:0]  user_cmd_idx;
    logic [31:0] user_cmd_arg;
    logic        xfer_req;
    logic [7:0]  xfer_tx;
    logic        xfer_done;
    logic [7:0]  xfer_rx;
    logic        cs_n, sclk_en, busy, ready, fail;
    logic [2:0]  fail_code;
    logic [31:0] ocr;
    logic        cmd_done;
    logic [7:0]  cmd_r1;
    logic        cmd_noresp, cmd_blocked;

    always #10 clk = ~clk;

    sdinit_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .poll_max(poll_max),
        .user_cmd_valid(user_cmd_valid), .user_cmd_idx(user_cmd_idx),
        .user_cmd_arg(user_cmd_arg), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_done(xfer_done), .xfer_rx(xfer_rx), .cs_n(cs_n), .sclk_en(sclk_en),
        .busy(busy), .ready(ready), .fail(fail), .fail_code(fail_code), .ocr(ocr),
        .cmd_done(cmd_done), .cmd_r1(cmd_r1), .cmd_noresp(cmd_noresp),
        .cmd_blocked(cmd_blocked));

    int checks   = 0;
    int failures = 0;

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // card model state
    int          idle_polls, polls_seen, resp_delay, noresp_idx;
    logic [7:0]  cmd0_r1;
    logic [31:0] ocr_val;
    bit          card_idle;
    int          fcnt, dummy_ff, first_dummy, bad_dummy, post_ff, frames_seen;
    logic [7:0]  fbuf [6];
    logic [7:0]  resp_q [$];
    logic [47:0] exp_q [$];

    function automatic logic [6:0] tb_crc7(input logic [39:0] m);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic top = c[6];
            c = c << 1;
            if (top != m[i]) c = c ^ 7'b0001001;
        end
        return c;
    endfunction

    // scoreboard driver side
    task automatic push_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] h = {2'b01, idx, arg};
        exp_q.push_back({h, tb_crc7(h), 1'b1});
    endtask

    // scoreboard monitor side: a complete frame arrived at the card
    task automatic frame_done();
        logic [47:0] got;
        logic [7:0]  r1;
        logic [5:0]  idx;
        frames_seen++;
        post_ff = 0;
        got = {fbuf[0], fbuf[1], fbuf[2], fbuf[3], fbuf[4], fbuf[5]};
        idx = fbuf[0][5:0];
        if (frames_seen == 1) begin
            first_dummy = dummy_ff;
            check_eq("R2 first frame is CMD0", {24'd0, fbuf[0]}, 32'h40);
        end
        if (fbuf[0] == 8'h40) check_eq("R2 CMD0 CRC byte", {24'd0, fbuf[5]}, 32'h95);
        if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R7 unexpected frame actual=%0h expected=none", got);
        end else begin
            logic [47:0] e = exp_q.pop_front();
            checks++;
            if (got !== e) begin
                failures++;
                $display("FAIL R3 frame actual=%0h expected=%0h", got, e);
            end
        end
        resp_q.delete();
        if (idx == 6'd0) begin r1 = cmd0_r1; card_idle = 1'b1; polls_seen = 0; end
        else if (idx == 6'd1) begin
            polls_seen++;
            r1 = (polls_seen <= idle_polls) ? 8'h01 : 8'h00;
            card_idle = r1[0];
        end else r1 = card_idle ? 8'h01 : 8'h00;
        if (int'(idx) != noresp_idx) begin
            for (int k = 0; k < resp_delay; k++) resp_q.push_back(8'hFF);
            resp_q.push_back(r1);
            if (idx == 6'd58) begin
                resp_q.push_back(ocr_val[31:24]); resp_q.push_back(ocr_val[23:16]);
                resp_q.push_back(ocr_val[15:8]);  resp_q.push_back(ocr_val[7:0]);
            end
        end
    endtask

    task automatic card_byte(input logic [7:0] tx, input logic cs, output logic [7:0] rx);
        rx = 8'hFF;
        if (cs) begin
            dummy_ff++;
            if (tx != 8'hFF) bad_dummy++;
            fcnt = 0;
        end else if (fcnt > 0) begin
            fbuf[fcnt] = tx;
            fcnt++;
            if (fcnt == 6) begin fcnt = 0; frame_done(); end
        end else if (tx[7:6] == 2'b01) begin
            fbuf[0] = tx;
            fcnt = 1;
        end else begin
            post_ff++;
            if (resp_q.size() > 0) rx = resp_q.pop_front();
        end
    endtask

    // byte transfer stub
    initial begin
        logic [7:0] rb;
        xfer_done = 1'b0;
        xfer_rx   = 8'hFF;
        forever begin
            @(negedge clk);
            if (xfer_req && rst_n) begin
                card_byte(xfer_tx, cs_n, rb);
                @(negedge clk);
                @(negedge clk);
                xfer_rx   = rb;
                xfer_done = 1'b1;
                @(negedge clk);
                xfer_done = 1'b0;
            end
        end
    end

    task automatic reset_dut();
        rst_n = 1'b0; start = 1'b0; user_cmd_valid = 1'b0;
        user_cmd_idx = '0; user_cmd_arg = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic card_setup(input int idle, input logic [7:0] r0, input int dly,
                              input int nores, input logic [31:0] ov);
        idle_polls = idle; cmd0_r1 = r0; resp_delay = dly; noresp_idx = nores;
        ocr_val = ov; polls_seen = 0; card_idle = 1'b1; fcnt = 0;
        resp_q.delete(); exp_q.delete();
        dummy_ff = 0; first_dummy = -1; bad_dummy = 0; post_ff = 0; frames_seen = 0;
    endtask

    task automatic run_init();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 30000; k++) begin
            if (ready || fail) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic user_cmd(input logic [5:0] idx, input logic [31:0] arg,
                            output bit blocked, output bit done);
        user_cmd_valid = 1'b1; user_cmd_idx = idx; user_cmd_arg = arg;
        @(negedge clk);
        user_cmd_valid = 1'b0;
        blocked = cmd_blocked;
        done = 1'b0;
        if (!blocked) begin
            for (int k = 0; k < 5000; k++) begin
                @(negedge clk);
                if (cmd_done) begin done = 1'b1; break; end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit blk, dn;
        int fs;
        poll_max = 16'd16;
        // reset state
        reset_dut();
        check_eq("R10 reset sclk_en", {31'd0, sclk_en}, 0);
        check_eq("R1 reset cs_n", {31'd0, cs_n}, 1);
        check_eq("R10 reset xfer_req", {31'd0, xfer_req}, 0);
        check_eq("R9 reset ready/fail/busy", {29'd0, busy, ready, fail}, 0);

        // normal start-up: three idle polls then ready
        card_setup(3, 8'h01, 2, -1, 32'hC0FF_8000);
        push_frame(0, 0);
        for (int i = 0; i < 4; i++) push_frame(1, 0);
        push_frame(58, 0);
        run_init();
        check_eq("R9 normal ready", {31'd0, ready}, 1);
        check_eq("R9 normal fail_code", {29'd0, fail_code}, 0);
        check_eq("R8 normal ocr", ocr, 32'hC0FF_8000);
        check_eq("R1 dummy bytes with cs high", first_dummy, 10);
        check_eq("R1 dummy bytes are FF", bad_dummy, 0);
        check_eq("R6 CMD1 polls", polls_seen, 4);
        check_eq("R6 all frames seen", exp_q.size(), 0);
        check_eq("R10 clock stopped when ready", {31'd0, sclk_en}, 0);

        // user CMD58 after ready
        ocr_val = 32'h8030_0000;
        push_frame(58, 0);
        user_cmd(58, 0, blk, dn);
        check_eq("R12 CMD58 done", {30'd0, blk, dn}, 1);
        check_eq("R12 CMD58 r1", {24'd0, cmd_r1}, 0);
        check_eq("R12 CMD58 ocr update", ocr, 32'h8030_0000);
        check_eq("R12 back to ready", {31'd0, ready}, 1);

        // CSD read with no answer uses the fixed window
        noresp_idx = 9;
        push_frame(9, 32'h1234_0000);
        user_cmd(9, 32'h1234_0000, blk, dn);
        check_eq("R4 CSD read noresp flag", {31'd0, cmd_noresp}, 1);
        check_eq("R4 CSD read r1", {24'd0, cmd_r1}, 32'hFF);
        check_eq("R4 CSD window bytes", post_ff, 8);

        // poll timeout
        reset_dut();
        poll_max = 16'd5;
        card_setup(1000, 8'h01, 1, -1, 32'hC0FF_8000);
        push_frame(0, 0);
        for (int i = 0; i < 5; i++) push_frame(1, 0);
        run_init();
        check_eq("R7 timeout fail code", {28'd0, fail, fail_code}, 32'hB);
        check_eq("R7 poll count", polls_seen, 5);
        fs = frames_seen;
        repeat (200) @(negedge clk);
        check_eq("R7 no further frames", frames_seen, fs);
        check_eq("R10 clock stopped on fail", {31'd0, sclk_en}, 0);

        // refused command while card idle
        user_cmd(17, 32'h100, blk, dn);
        check_eq("R11 CMD17 refused", {31'd0, blk}, 1);
        repeat (50) @(negedge clk);
        check_eq("R11 no frame after refusal", frames_seen, fs);
        check_eq("R11 bus quiet after refusal", {31'd0, xfer_req}, 0);

        // permitted commands while idle
        push_frame(58, 0);
        user_cmd(58, 0, blk, dn);
        check_eq("R11 CMD58 permitted while idle", {30'd0, blk, dn}, 1);
        check_eq("R12 CMD58 idle r1", {24'd0, cmd_r1}, 1);
        check_eq("R12 back to fail", {31'd0, fail}, 1);
        push_frame(1, 0);
        user_cmd(1, 32'hDEAD_BEEF, blk, dn);
        check_eq("R6 user CMD1 done", {30'd0, blk, dn}, 1);
        check_eq("R6 user CMD1 zero argument", exp_q.size(), 0);

        // voltage mismatch
        reset_dut();
        poll_max = 16'd16;
        card_setup(0, 8'h01, 0, -1, 32'h8000_0080);
        push_frame(0, 0); push_frame(1, 0); push_frame(58, 0);
        run_init();
        check_eq("R9 voltage fail code", {28'd0, fail, fail_code}, 32'hC);
        check_eq("R8 mismatch ocr shown", ocr, 32'h8000_0080);

        // no answer to CMD0
        reset_dut();
        card_setup(0, 8'h01, 0, 0, 32'hC0FF_8000);
        push_frame(0, 0);
        run_init();
        check_eq("R4 CMD0 noresp code", {28'd0, fail, fail_code}, 32'h9);
        check_eq("R4 CMD0 window bytes", post_ff, 8);

        // answer in the last byte of the window
        reset_dut();
        card_setup(0, 8'h01, 7, -1, 32'h0030_0000);
        push_frame(0, 0); push_frame(1, 0); push_frame(58, 0);
        run_init();
        check_eq("R4 late R1 accepted", {31'd0, ready}, 1);

        // answer one byte too late
        reset_dut();
        card_setup(0, 8'h01, 8, -1, 32'h0030_0000);
        push_frame(0, 0);
        run_init();
        check_eq("R4 R1 beyond window", {28'd0, fail, fail_code}, 32'h9);

        // bad CMD0 response
        reset_dut();
        card_setup(0, 8'h05, 0, -1, 32'h0030_0000);
        push_frame(0, 0);
        run_init();
        check_eq("R5 bad CMD0 r1", {28'd0, fail, fail_code}, 32'hA);

        // poll limit boundary: one idle reply below limit
        reset_dut();
        poll_max = 16'd2;
        card_setup(1, 8'h01, 0, -1, 32'h0030_0000);
        push_frame(0, 0); push_frame(1, 0); push_frame(1, 0); push_frame(58, 0);
        run_init();
        check_eq("R7 ready just under limit", {31'd0, ready}, 1);

        // poll limit boundary: idle replies reach limit
        reset_dut();
        card_setup(2, 8'h01, 0, -1, 32'h0030_0000);
        push_frame(0, 0); push_frame(1, 0); push_frame(1, 0);
        run_init();
        check_eq("R7 timeout at limit", {28'd0, fail, fail_code}, 32'hB);
        check_eq("R7 frames at limit", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule